// File: doc/BRIEF.md
# Segmented Block Copy and Fill Engine

The engine moves a run of elements from one paged memory segment to another, or writes one repeated value over a run of elements in a destination segment. A client gives it a data segment and source offset, a destination segment and offset, a signed 16-bit element count, a byte/word granularity bit and a fill value, then pulses start. The sign of the count picks the operation: a positive count copies that many elements, a negative count fills as many elements as its magnitude, and zero finishes at once.

While it runs, the engine drives a single synchronous memory port that carries a segment number, an offset, read and write strobes, two byte enables and write data. Read data is returned on the cycle after a read strobe. Busy stays high for the whole run and done pulses once at the end. Page mapping, bus arbitration and interrupt signalling belong to the surrounding system.

Top module: `seg_block_mover`

## Requirements
- R1: After reset, busy, done, the read strobe and the write strobe are all low.
- R2: With a positive count N, the engine makes N element transfers. Each transfer is one read cycle in the data segment at the source offset, followed in the next cycle by one write cycle in the destination segment. A copy keeps busy high for exactly 2N cycles.
- R3: With a negative count, the engine writes the fill value (latched at start) to as many elements as the magnitude of the count. It makes one write per cycle and no reads, and keeps busy high for exactly that many cycles.
- R4: Source and destination offsets advance by 2 per element in word mode and by 1 in byte mode, and wrap modulo 65536 within their segment.
- R5: A zero count raises done in the cycle after start, keeps busy low and makes no memory access.
- R6: Bit 0 of the offset selects the byte lane. In byte mode, an even offset uses bits 7:0 with byte enable 01 and an odd offset uses bits 15:8 with byte enable 10. A byte copy takes the byte from the source lane and places it in the destination lane. In word mode, the byte enable is 11.
- R7: A start request while busy is high is ignored: the running operation keeps its own segment, offsets, count and fill value.
- R8: Done is a single-cycle pulse in the cycle after the last write, and busy is low in that cycle.
- R9: The read and write strobes are never high together.
- R10: The most negative count, 0x8000, fills 32768 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on a clock edge while idle |
| byte_mode_i | input | 1 | 1 moves bytes, 0 moves 16-bit words |
| data_seg_i | input | 8 | Segment that holds the source |
| dst_seg_i | input | 8 | Segment that holds the destination |
| src_off_i | input | 16 | Source offset |
| dst_off_i | input | 16 | Destination offset |
| count_i | input | 16 | Signed element count; negative selects fill |
| fill_value_i | input | 16 | Fill value; byte mode uses bits 7:0 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_seg_o | output | 8 | Segment of the current access |
| mem_addr_o | output | 16 | Offset of the current access |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_be_o | output | 2 | Byte enables for the write |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read strobe |

## Verification
The bench aims at the count encoding. A count of zero must finish without touching memory; an engine that treats it as 65536 runs a very long time. Counts of -1 and 0x8000 must fill one element and 32768 elements; a sign or magnitude slip would fill the wrong length or would copy instead. Offsets placed near 0xFFFF check the wrap, where a carry that leaks into the segment would corrupt another page. Byte copies between odd and even offsets check lane steering, which a swapped enable or an unshifted byte would break. A second start in the middle of a fill checks that the latched fill value and length survive, since an engine that accepts the new request would write the new pattern or a different number of elements.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FILL  = 2'd3
    } blkmv_state_e;
endpackage

// File: rtl/blkmv_count_decode.sv
module blkmv_count_decode #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    output logic             is_fill_o,
    output logic             is_zero_o,
    output logic [CNT_W-1:0] mag_o
);
    // The sign bit selects fill. The two's complement magnitude of the most
    // negative value is still correct when read as unsigned.
    always_comb begin
        is_fill_o = count_i[CNT_W-1];
        is_zero_o = (count_i == '0);
        mag_o     = is_fill_o ? ((~count_i) + CNT_W'(1)) : count_i;
    end
endmodule

// File: rtl/blkmv_addr_step.sv
module blkmv_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_mode_i,
    output logic [ADDR_W-1:0] addr_o
);
    // The add is truncated to ADDR_W, so the offset wraps within its segment.
    always_comb begin
        addr_o = addr_i + (byte_mode_i ? ADDR_W'(1) : ADDR_W'(2));
    end
endmodule

// File: rtl/blkmv_lane_route.sv
module blkmv_lane_route (
    input  logic        byte_mode_i,
    input  logic        fill_mode_i,
    input  logic        src_lsb_i,
    input  logic        dst_lsb_i,
    input  logic [15:0] rdata_i,
    input  logic [15:0] fill_i,
    output logic [15:0] wdata_o,
    output logic [1:0]  be_o
);
    logic [7:0]  byte_pick;
    logic [15:0] word_pick;

    always_comb begin
        word_pick = fill_mode_i ? fill_i : rdata_i;
        if (fill_mode_i) begin
            byte_pick = fill_i[7:0];
        end else begin
            byte_pick = src_lsb_i ? rdata_i[15:8] : rdata_i[7:0];
        end
        if (byte_mode_i) begin
            wdata_o = {byte_pick, byte_pick};
            be_o    = dst_lsb_i ? 2'b10 : 2'b01;
        end else begin
            wdata_o = word_pick;
            be_o    = 2'b11;
        end
    end
endmodule

// File: rtl/seg_block_mover.sv
module seg_block_mover
    import blkmv_pkg::*;
#(
    parameter int SEG_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              byte_mode_i,
    input  logic [SEG_W-1:0]  data_seg_i,
    input  logic [SEG_W-1:0]  dst_seg_i,
    input  logic [ADDR_W-1:0] src_off_i,
    input  logic [ADDR_W-1:0] dst_off_i,
    input  logic [ADDR_W-1:0] count_i,
    input  logic [15:0]       fill_value_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [SEG_W-1:0]  mem_seg_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [1:0]        mem_be_o,
    output logic [15:0]       mem_wdata_o,
    input  logic [15:0]       mem_rdata_i
);
    localparam int CNT_W = ADDR_W;

    typedef struct packed {
        blkmv_state_e      st;
        logic              byte_mode;
        logic [SEG_W-1:0]  src_seg;
        logic [SEG_W-1:0]  dst_seg;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  rem;
        logic [15:0]       fill;
        logic              done;
    } blkmv_regs_t;

    blkmv_regs_t r_q, r_d;

    logic              cnt_is_fill, cnt_is_zero;
    logic [CNT_W-1:0]  cnt_mag;
    logic [ADDR_W-1:0] src_next, dst_next;
    logic              last_elem;

    blkmv_count_decode #(.CNT_W(CNT_W)) i_count (
        .count_i   (count_i),
        .is_fill_o (cnt_is_fill),
        .is_zero_o (cnt_is_zero),
        .mag_o     (cnt_mag)
    );

    blkmv_addr_step #(.ADDR_W(ADDR_W)) i_src_step (
        .addr_i      (r_q.src),
        .byte_mode_i (r_q.byte_mode),
        .addr_o      (src_next)
    );

    blkmv_addr_step #(.ADDR_W(ADDR_W)) i_dst_step (
        .addr_i      (r_q.dst),
        .byte_mode_i (r_q.byte_mode),
        .addr_o      (dst_next)
    );

    blkmv_lane_route i_lane (
        .byte_mode_i (r_q.byte_mode),
        .fill_mode_i (r_q.st == ST_FILL),
        .src_lsb_i   (r_q.src[0]),
        .dst_lsb_i   (r_q.dst[0]),
        .rdata_i     (mem_rdata_i),
        .fill_i      (r_q.fill),
        .wdata_o     (mem_wdata_o),
        .be_o        (mem_be_o)
    );

    assign last_elem = (r_q.rem == CNT_W'(1));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.byte_mode = byte_mode_i;
                    r_d.src_seg   = data_seg_i;
                    r_d.dst_seg   = dst_seg_i;
                    r_d.src       = src_off_i;
                    r_d.dst       = dst_off_i;
                    r_d.rem       = cnt_mag;
                    r_d.fill      = fill_value_i;
                    if (cnt_is_zero) begin
                        r_d.done = 1'b1;
                    end else if (cnt_is_fill) begin
                        r_d.st = ST_FILL;
                    end else begin
                        r_d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                r_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                r_d.src = src_next;
                r_d.dst = dst_next;
                r_d.rem = r_q.rem - CNT_W'(1);
                if (last_elem) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_READ;
                end
            end
            ST_FILL: begin
                r_d.dst = dst_next;
                r_d.rem = r_q.rem - CNT_W'(1);
                if (last_elem) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy_o     = (r_q.st != ST_IDLE);
        done_o     = r_q.done;
        mem_rd_o   = (r_q.st == ST_READ);
        mem_wr_o   = (r_q.st == ST_WRITE) || (r_q.st == ST_FILL);
        mem_seg_o  = mem_rd_o ? r_q.src_seg : r_q.dst_seg;
        mem_addr_o = mem_rd_o ? r_q.src : r_q.dst;
    end

    // R9: the strobes are exclusive.
    a_r9_strobe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_o && mem_wr_o));

    // R2: every read is followed by a write in the next cycle.
    a_r2_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_o |=> mem_wr_o);

    // R4: back-to-back fill writes advance the offset by one element.
    a_r4_fill_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_FILL && $past(r_q.st == ST_FILL))
        |-> (mem_addr_o == $past(mem_addr_o) + (r_q.byte_mode ? ADDR_W'(1) : ADDR_W'(2))));

    // R5: a zero count finishes at once without going busy.
    a_r5_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && count_i == '0) |=> (done_o && !busy_o));

    // R7: a start request during a run leaves the latched fill value alone.
    a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(r_q.fill));

    // R8: done is never raised while the engine is still busy.
    a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
endmodule

// File: tb/test_seg_block_mover.sv
module test_seg_block_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        byte_mode = 1'b0;
    logic [7:0]  data_seg = '0;
    logic [7:0]  dst_seg = '0;
    logic [15:0] src_off = '0;
    logic [15:0] dst_off = '0;
    logic [15:0] count = '0;
    logic [15:0] fill_value = '0;
    logic        busy, done;
    logic [7:0]  mem_seg;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [int];
    logic [7:0] exp_mem [int];

    int rd_cnt, wr_cnt, busy_cyc, done_cnt, seg_bad;

    always #2 clk = ~clk;

    seg_block_mover i_seg_block_mover (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .byte_mode_i (byte_mode),
        .data_seg_i (data_seg), .dst_seg_i (dst_seg), .src_off_i (src_off),
        .dst_off_i (dst_off), .count_i (count), .fill_value_i (fill_value),
        .busy_o (busy), .done_o (done), .mem_seg_o (mem_seg), .mem_addr_o (mem_addr),
        .mem_rd_o (mem_rd), .mem_wr_o (mem_wr), .mem_be_o (mem_be),
        .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata)
    );

    function automatic int key(input logic [7:0] s, input logic [15:0] a);
        return int'({8'h00, s, a});
    endfunction

    function automatic logic [7:0] init_byte(input int k);
        logic [31:0] kv = k;
        return kv[7:0] ^ kv[15:8] ^ (kv[23:16] * 8'd3) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mem_get(input int k);
        return mem.exists(k) ? mem[k] : init_byte(k);
    endfunction

    function automatic logic [7:0] exp_get(input int k);
        return exp_mem.exists(k) ? exp_mem[k] : init_byte(k);
    endfunction

    // Memory model: read data registered one cycle after the read strobe.
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= {mem_get(key(mem_seg, {mem_addr[15:1], 1'b1})),
                          mem_get(key(mem_seg, {mem_addr[15:1], 1'b0}))};
        end
        if (mem_wr) begin
            if (mem_be[0]) mem[key(mem_seg, {mem_addr[15:1], 1'b0})] = mem_wdata[7:0];
            if (mem_be[1]) mem[key(mem_seg, {mem_addr[15:1], 1'b1})] = mem_wdata[15:8];
        end
    end

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                rd_cnt++;
                if (mem_seg != data_seg) seg_bad++;
            end
            if (mem_wr) begin
                wr_cnt++;
                if (mem_seg != dst_seg) seg_bad++;
            end
            if (mem_rd && mem_wr) seg_bad++;
            if (busy) busy_cyc++;
            if (done) done_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Sequential reference of the requirements, applied to exp_mem.
    task automatic model(input bit bm, input logic [7:0] ds, input logic [7:0] dsg,
                         input logic [15:0] so, input logic [15:0] doff,
                         input int n, input bit is_fill, input logic [15:0] fv);
        logic [15:0] s = so;
        logic [15:0] d = doff;
        for (int i = 0; i < n; i++) begin
            if (bm) begin
                exp_mem[key(dsg, d)] = is_fill ? fv[7:0] : exp_get(key(ds, s));
                s = s + 16'd1;
                d = d + 16'd1;
            end else begin
                exp_mem[key(dsg, d)]         = is_fill ? fv[7:0]  : exp_get(key(ds, s));
                exp_mem[key(dsg, d | 16'd1)] = is_fill ? fv[15:8] : exp_get(key(ds, s | 16'd1));
                s = s + 16'd2;
                d = d + 16'd2;
            end
        end
    endtask

    task automatic run_op(input bit bm, input logic [7:0] ds, input logic [7:0] dsg,
                          input logic [15:0] so, input logic [15:0] doff,
                          input logic [15:0] cnt, input logic [15:0] fv,
                          input bit inject, input string req);
        int n;
        bit is_fill = cnt[15];
        int bytes_per;
        int cyc;
        int mism;
        logic [15:0] d;
        n = is_fill ? (65536 - int'(cnt)) : int'(cnt);
        bytes_per = bm ? 1 : 2;
        exp_mem = mem;
        model(bm, ds, dsg, so, doff, n, is_fill, fv);
        rd_cnt = 0; wr_cnt = 0; busy_cyc = 0; done_cnt = 0; seg_bad = 0;
        @(negedge clk);
        byte_mode = bm; data_seg = ds; dst_seg = dsg; src_off = so;
        dst_off = doff; count = cnt; fill_value = fv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 70000) begin
            if (inject && cyc == 3) begin
                fill_value = 16'h1234; count = 16'hFFCE; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done == 1'b1, req, "done seen before timeout", done, 1);
        check(busy == 1'b0, "R8", "busy low with done", busy, 0);
        @(negedge clk);
        check(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);
        check(wr_cnt == n, req, "write count", wr_cnt, n);
        check(rd_cnt == (is_fill ? 0 : n), req, "read count", rd_cnt, is_fill ? 0 : n);
        check(busy_cyc == (is_fill ? n : 2 * n), req, "busy cycles", busy_cyc,
              is_fill ? n : 2 * n);
        check(seg_bad == 0, "R9", "segment or strobe misuse", seg_bad, 0);
        mism = 0;
        d = doff - 16'd1;
        for (int i = 0; i < n * bytes_per + 2; i++) begin
            if (mem_get(key(dsg, d)) != exp_get(key(dsg, d))) begin
                if (mism == 0) begin
                    $display("FAIL %s data at seg %0h off %0h: actual %0h expected %0h",
                             req, dsg, d, mem_get(key(dsg, d)), exp_get(key(dsg, d)));
                end
                mism++;
            end
            d = d + 16'd1;
        end
        checks++;
        if (mism != 0) errors++;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
        check(mem_rd == 1'b0 && mem_wr == 1'b0, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {busy, done}, 0);

        // R5: zero count.
        rd_cnt = 0; wr_cnt = 0;
        count = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R5", "done after zero count", done, 1);
        check(busy == 1'b0, "R5", "busy stays low", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R5", "done drops", done, 0);
        check(rd_cnt == 0 && wr_cnt == 0, "R5", "no access", rd_cnt + wr_cnt, 0);

        // Directed corner cases.
        run_op(1'b0, 8'h10, 8'h20, 16'h0040, 16'h0100, 16'd5, 16'h0, 1'b0, "R2");
        run_op(1'b1, 8'h11, 8'h21, 16'h0033, 16'h0200, 16'd7, 16'h0, 1'b0, "R6");
        run_op(1'b1, 8'h12, 8'h22, 16'h0100, 16'h0301, 16'd6, 16'h0, 1'b0, "R6");
        run_op(1'b0, 8'h13, 8'h23, 16'h0, 16'hFFFE, 16'hFFFD, 16'hBEEF, 1'b0, "R4");
        run_op(1'b1, 8'h14, 8'h24, 16'hFFFE, 16'hFFFD, 16'd5, 16'h0, 1'b0, "R4");
        run_op(1'b1, 8'h15, 8'h25, 16'h0, 16'h0400, 16'hFFFF, 16'h00C3, 1'b0, "R3");
        run_op(1'b0, 8'h16, 8'h03, 16'h0, 16'h0100, 16'hFFF6, 16'hA5A5, 1'b1, "R7");
        run_op(1'b1, 8'h17, 8'h09, 16'h0, 16'h0000, 16'h8000, 16'h005E, 1'b0, "R10");

        // Constrained random operations.
        for (int i = 0; i < 24; i++) begin
            bit          bm  = 1'($urandom_range(0, 1));
            bit          fl  = 1'($urandom_range(0, 1));
            int          n   = $urandom_range(1, 40);
            logic [15:0] so  = 16'($urandom);
            logic [15:0] doff = 16'($urandom);
            logic [15:0] cnt = fl ? 16'(-n) : 16'(n);
            if (!bm) begin
                so[0] = 1'b0;
                doff[0] = 1'b0;
            end
            run_op(bm, 8'($urandom), 8'($urandom), so, doff, cnt, 16'($urandom), 1'b0,
                   fl ? "R3" : "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule